// File: doc/BRIEF.md
# Shared-Bus Five-Stage Pipeline with Load Stall

This block is a small in-order pipeline with five stages: fetch, decode, execute, memory and writeback. A single memory port serves both instruction fetch and load data. Each stage keeps its own instruction register, and an instruction moves one stage per clock. The decode stage reads both source registers named by the instruction word on every cycle, whatever the opcode. Execute adds the two operands. For a load, that sum is the data address. Writeback puts either the sum or the loaded word into the destination register.

Only one agent can use the shared port in a cycle. When a load reaches the memory stage it takes the port. Fetch is frozen for that cycle: the PC holds and a bubble (all-zero word) goes into the decode register in place of a fetched word. On the next cycle, fetch issues the same PC again. The memory answers in the same cycle it is asked, so a load completes without further waiting.

There is no forwarding. Software must keep a producer and a consumer at least four fetch slots apart. A debug port reads any register combinationally.

Top module: `shbus_pipe`

## Requirements
- R1: A synchronous reset sets the PC to 0 and clears every stage instruction register to the all-zero word. It also loads register i with RST_BASE + i*RST_STEP (32 + 8*i at the defaults). In the first cycle after reset, the port fetches address 0.
- R2: The instruction word is 16 bits. Bits [15:12] hold the opcode, [11:8] the destination register, [7:4] the first source register and [3:0] the second source register. Opcode 0 is NOP, 1 is ADD and 2 is LDR. Every other opcode behaves as NOP.
- R3: In every cycle with no load in the memory stage, the port carries a fetch: `mem_rd`=1, `mem_is_data`=0 and `mem_addr` equal to the PC. The PC then advances by one.
- R4: In the cycle a load occupies the memory stage (three cycles after its fetch), the port carries a data read: `mem_rd`=1, `mem_is_data`=1. The address is the low AW bits of the sum of its two source registers, as read in decode. A fetch and a data read never share a cycle.
- R5: In a stall cycle the PC holds. The next cycle fetches that same address again, so every program address is fetched exactly once, in order.
- R6: In a stall cycle, the decode register takes the all-zero word, and the word on the port is not executed as an instruction.
- R7: A load writes the word read from memory into its destination register at the end of the fourth cycle after its fetch cycle. The register holds its old value until then.
- R8: An ADD writes the 16-bit sum of its source registers into its destination at the end of the fourth cycle after its fetch cycle.
- R9: A NOP (and any unused opcode) writes no register and makes no data request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | AW | Shared memory port address |
| mem_rd | output | 1 | Read strobe of the shared port |
| mem_is_data | output | 1 | 1 when the current access is a load read, 0 for a fetch |
| mem_rdata | input | DW | Read data, returned in the same cycle |
| dbg_idx | input | 4 | Register selected for the debug view |
| dbg_val | output | DW | Contents of the selected register |

## Verification
The bench sweeps every pair of load source registers. For each pair it checks three things: the data address, the cycle in which the port switches to data, and the cycle the destination changes. A design that let the load fetch the wrong operands, or wrote one cycle early or late, would fail there.

Each sweep also checks the fetch just after the stall. A PC that advanced during the stall would show up as a skipped address. A mixed program of loads and adds then tracks the fetch order, so a lost or repeated fetch shows up as an address mismatch. Its final register file is compared with a sequential model, so a stalled word that leaked into decode would corrupt a register.

A run of NOPs and unused opcodes must leave every register at its reset seed and never raise a data request.

// File: rtl/shp_pkg.sv
package shp_pkg;

  localparam int IW  = 16;
  localparam int RFW = 4;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_NOP = 4'd0,
    OP_ADD = 4'd1,
    OP_LDR = 4'd2
  } op_e;

  typedef struct packed {
    logic [OPW-1:0] op;
    logic [RFW-1:0] rd;
    logic [RFW-1:0] rn;
    logic [RFW-1:0] rm;
  } instr_t;

  localparam instr_t BUBBLE = '0;

  function automatic logic is_load(instr_t i);
    return i.op == OP_LDR;
  endfunction

  function automatic logic is_add(instr_t i);
    return i.op == OP_ADD;
  endfunction

  function automatic logic writes_reg(instr_t i);
    return is_load(i) || is_add(i);
  endfunction

  function automatic logic [31:0] reg_seed(int idx, int base, int step);
    return 32'(base + step * idx);
  endfunction

endpackage

// File: rtl/shp_fetch.sv
module shp_fetch
  import shp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic [IW-1:0] fetch_word,
  output logic [AW-1:0] pc,
  output instr_t        ir_id
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      ir_id <= BUBBLE;
    end else if (stall) begin
      ir_id <= BUBBLE;
    end else begin
      pc    <= pc + AW'(1);
      ir_id <= instr_t'(fetch_word);
    end
  end

endmodule

// File: rtl/shp_regfile.sv
module shp_regfile
  import shp_pkg::*;
#(
  parameter int DW       = 16,
  parameter int NREG     = 16,
  parameter int RST_BASE = 32,
  parameter int RST_STEP = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [RFW-1:0] rsel_a,
  input  logic [RFW-1:0] rsel_b,
  output logic [DW-1:0]  rval_a,
  output logic [DW-1:0]  rval_b,
  input  logic           wen,
  input  logic [RFW-1:0] wsel,
  input  logic [DW-1:0]  wval,
  input  logic [RFW-1:0] dsel,
  output logic [DW-1:0]  dval
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    for (int k = 0; k < NREG; k++) begin
      if (rst)
        regs[k] <= DW'(reg_seed(k, RST_BASE, RST_STEP));
      else if (wen && (wsel == RFW'(k)))
        regs[k] <= wval;
    end
  end

  assign rval_a = regs[rsel_a];
  assign rval_b = regs[rsel_b];
  assign dval   = regs[dsel];

endmodule

// File: rtl/shp_busarb.sv
module shp_busarb #(
  parameter int AW = 8
) (
  input  logic          rst,
  input  logic          mem_load,
  input  logic [AW-1:0] data_addr,
  input  logic [AW-1:0] pc,
  output logic          fetch_req,
  output logic          load_req,
  output logic [AW-1:0] addr,
  output logic          rd,
  output logic          is_data
);

  always_comb begin
    load_req  = !rst && mem_load;
    fetch_req = !rst && !mem_load;
    addr      = mem_load ? data_addr : pc;
    rd        = load_req || fetch_req;
    is_data   = load_req;
  end

endmodule

// File: rtl/shbus_pipe.sv
module shbus_pipe
  import shp_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int RST_BASE = 32,
  parameter int RST_STEP = 8
) (
  input  logic           clk,
  input  logic           rst,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_rd,
  output logic           mem_is_data,
  input  logic [DW-1:0]  mem_rdata,
  input  logic [RFW-1:0] dbg_idx,
  output logic [DW-1:0]  dbg_val
);

  localparam int NREG = 1 << RFW;

  function automatic logic [DW-1:0] op_sum(logic [DW-1:0] a, logic [DW-1:0] b);
    return a + b;
  endfunction

  // stage instruction registers
  instr_t ir_id, ir_ex, ir_mem, ir_wb;

  // datapath registers
  logic [DW-1:0] opa_ex, opb_ex;
  logic [DW-1:0] alu_mem, alu_wb;
  logic [AW-1:0] dmar;
  logic [DW-1:0] lmdr;

  // named internal events
  logic          stall, fetch_req, load_req, mem_load;
  logic [AW-1:0] pc;
  logic [DW-1:0] rf_a, rf_b;
  logic          wb_we;
  logic [DW-1:0] wb_val;
  logic [DW-1:0] ex_sum;

  assign mem_load = is_load(ir_mem);
  assign stall    = mem_load;
  assign ex_sum   = op_sum(opa_ex, opb_ex);

  shp_fetch #(.AW(AW)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .stall      (stall),
    .fetch_word (mem_rdata[IW-1:0]),
    .pc         (pc),
    .ir_id      (ir_id)
  );

  shp_busarb #(.AW(AW)) u_arb (
    .rst       (rst),
    .mem_load  (mem_load),
    .data_addr (dmar),
    .pc        (pc),
    .fetch_req (fetch_req),
    .load_req  (load_req),
    .addr      (mem_addr),
    .rd        (mem_rd),
    .is_data   (mem_is_data)
  );

  shp_regfile #(
    .DW       (DW),
    .NREG     (NREG),
    .RST_BASE (RST_BASE),
    .RST_STEP (RST_STEP)
  ) u_rf (
    .clk    (clk),
    .rst    (rst),
    .rsel_a (ir_id.rn),
    .rsel_b (ir_id.rm),
    .rval_a (rf_a),
    .rval_b (rf_b),
    .wen    (wb_we),
    .wsel   (ir_wb.rd),
    .wval   (wb_val),
    .dsel   (dbg_idx),
    .dval   (dbg_val)
  );

  // ID -> EX: both operands read regardless of opcode
  always_ff @(posedge clk) begin
    if (rst) begin
      ir_ex  <= BUBBLE;
      opa_ex <= '0;
      opb_ex <= '0;
    end else begin
      ir_ex  <= ir_id;
      opa_ex <= rf_a;
      opb_ex <= rf_b;
    end
  end

  // EX -> MEM: sum goes to ALU output and data address register
  always_ff @(posedge clk) begin
    if (rst) begin
      ir_mem  <= BUBBLE;
      alu_mem <= '0;
      dmar    <= '0;
    end else begin
      ir_mem  <= ir_ex;
      alu_mem <= ex_sum;
      dmar    <= ex_sum[AW-1:0];
    end
  end

  // MEM -> WB: capture load data in the same cycle as the request
  always_ff @(posedge clk) begin
    if (rst) begin
      ir_wb  <= BUBBLE;
      alu_wb <= '0;
      lmdr   <= '0;
    end else begin
      ir_wb  <= ir_mem;
      alu_wb <= alu_mem;
      if (mem_load)
        lmdr <= mem_rdata;
    end
  end

  // WB source select
  assign wb_we  = writes_reg(ir_wb);
  assign wb_val = is_load(ir_wb) ? lmdr : alu_wb;

  bind shbus_pipe shp_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fetch_req (fetch_req),
    .load_req  (load_req),
    .mem_rd    (mem_rd),
    .pc        (pc),
    .id_word   (ir_id),
    .wb_word   (ir_wb),
    .wb_we     (wb_we)
  );

endmodule

// File: rtl/shp_chk.sv
module shp_chk
  import shp_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          fetch_req,
  input logic          load_req,
  input logic          mem_rd,
  input logic [AW-1:0] pc,
  input instr_t        id_word,
  input instr_t        wb_word,
  input logic          wb_we
);

  AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(fetch_req && load_req)); // R4

  AST_PORT_ALWAYS_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_rd); // R3

  AST_FETCH_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    fetch_req |=> pc == $past(pc) + AW'(1)); // R3

  AST_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
    load_req |=> pc == $past(pc)); // R5

  AST_BUBBLE_INTO_ID: assert property (@(posedge clk) disable iff (rst)
    load_req |=> id_word == BUBBLE); // R6

  AST_LOAD_REACHES_WB: assert property (@(posedge clk) disable iff (rst)
    load_req |=> (wb_word.op == OP_LDR) && wb_we); // R7

  AST_NOP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wb_word.op != OP_LDR && wb_word.op != OP_ADD) |-> !wb_we); // R9

endmodule

// File: tb/sim_shbus_pipe.sv
`timescale 1ns/1ps
module sim_shbus_pipe;

  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic          mem_rd;
  logic          mem_is_data;
  logic [DW-1:0] mem_rdata;
  logic [3:0]    dbg_idx = '0;
  logic [DW-1:0] dbg_val;

  logic [15:0] mem [256];
  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr];

  shbus_pipe #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_is_data(mem_is_data), .mem_rdata(mem_rdata),
    .dbg_idx(dbg_idx), .dbg_val(dbg_val)
  );

  function automatic logic [15:0] seed(int i);
    return 16'(32 + 8 * i);
  endfunction

  function automatic logic [15:0] enc(int op, int rd, int rn, int rm);
    return {4'(op), 4'(rd), 4'(rn), 4'(rm)};
  endfunction

  task automatic check(string req, logic ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic fill_mem();
    for (int a = 0; a < 256; a++)
      mem[a] = (a < 16) ? 16'h0 : 16'((a * 773 + 16'h1234) ^ (a << 7));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    #1;
  endtask

  task automatic peek(int idx, output logic [15:0] v);
    dbg_idx = 4'(idx);
    #1;
    v = dbg_val;
  endtask

  logic [15:0] v;
  logic [15:0] model [16];
  int exp_data [64];
  int load_addr_q [8];

  initial begin
    // R1: reset state
    fill_mem();
    do_reset();
    check("R1", mem_addr == 0 && !mem_is_data && mem_rd, mem_addr, 0);
    for (int i = 0; i < 16; i++) begin
      peek(i, v);
      check("R1", v == seed(i), v, seed(i));
    end

    // R4 R5 R7: sweep of every source register pair for a single load
    for (int rn = 0; rn < 16; rn++) begin
      for (int rm = 0; rm < 16; rm++) begin
        int rd;
        int addr;
        rd = (rn + rm + 5) % 16;
        addr = (seed(rn) + seed(rm)) & 8'hFF;
        fill_mem();
        mem[0] = enc(2, rd, rn, rm);
        dbg_idx = 4'(rd);
        do_reset();
        step(); step();
        check("R3", mem_addr == 2 && !mem_is_data, mem_addr, 2);
        step();
        check("R4", mem_is_data && mem_addr == AW'(addr), mem_addr, addr);
        step();
        check("R5", mem_addr == 3 && !mem_is_data, mem_addr, 3);
        check("R7", dbg_val == seed(rd), dbg_val, seed(rd));
        step();
        check("R7", dbg_val == mem[addr], dbg_val, mem[addr]);
      end
    end

    // R3 R4 R5 R6 R8: mixed program, fetch order and final state
    fill_mem();
    mem[0] = enc(2, 1, 2, 3);
    mem[1] = enc(1, 4, 5, 6);
    mem[2] = enc(2, 7, 8, 9);
    mem[3] = enc(2, 10, 11, 12);
    mem[4] = enc(1, 13, 14, 15);
    mem[5] = enc(1, 0, 1, 4);
    for (int i = 0; i < 16; i++) model[i] = seed(i);
    begin
      int nl;
      nl = 0;
      for (int p = 0; p < 6; p++) begin
        logic [15:0] w;
        w = mem[p];
        if (w[15:12] == 4'd2) begin
          load_addr_q[nl] = (model[w[7:4]] + model[w[3:0]]) & 8'hFF;
          nl++;
          model[w[11:8]] = mem[(model[w[7:4]] + model[w[3:0]]) & 8'hFF];
        end else if (w[15:12] == 4'd1) begin
          model[w[11:8]] = model[w[7:4]] + model[w[3:0]];
        end
      end
    end
    for (int i = 0; i < 64; i++) exp_data[i] = 0;
    dbg_idx = 4'd4;
    do_reset();
    begin
      int fpc;
      int li;
      fpc = 0;
      li = 0;
      for (int c = 0; c <= 16; c++) begin
        if (c > 0) step();
        check("R4", mem_is_data == (exp_data[c] != 0), mem_is_data, exp_data[c]);
        if (mem_is_data) begin
          check("R4", mem_addr == AW'(load_addr_q[li]), mem_addr, load_addr_q[li]);
          li++;
        end else begin
          check("R5", mem_addr == AW'(fpc), mem_addr, fpc);
          if (mem[fpc][15:12] == 4'd2) exp_data[c + 3] = 1;
          fpc++;
        end
        if (c == 5) check("R8", dbg_val == seed(4), dbg_val, seed(4));
        if (c == 6) check("R8", dbg_val == 16'(seed(5) + seed(6)), dbg_val, 16'(seed(5) + seed(6)));
      end
      check("R5", li == 3, li, 3);
    end
    for (int i = 0; i < 16; i++) begin
      peek(i, v);
      check("R6", v == model[i], v, model[i]);
    end

    // R9 R2: NOPs and unused opcodes change nothing
    fill_mem();
    mem[1] = 16'hF123;
    mem[2] = 16'h7456;
    mem[3] = enc(0, 9, 1, 2);
    do_reset();
    for (int c = 1; c <= 12; c++) begin
      step();
      check("R9", !mem_is_data && mem_addr == AW'(c), mem_addr, c);
    end
    for (int i = 0; i < 16; i++) begin
      peek(i, v);
      check("R2", v == seed(i), v, seed(i));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog cycle %0d: actual hang expected completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule